// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits on the host side of a byte-wide, command-driven flash device. A user port hands it one request at a time: erase the block that holds an address, program one byte, or read one byte. The sequencer turns each request into the command writes the device expects. It then reads the device's status byte over and over until the ready flag is set. Next it decodes the error flags into one result code and returns that code on a single-cycle response strobe.

An erase keeps running in the background. While the sequencer is polling an erase, it still accepts a read request. It suspends the erase, waits for the device to settle, and switches the device to array mode. It then fetches the byte and resumes the erase. If the status byte after the suspend shows that the erase had already finished, the sequencer reports the erase and does not resume. It also clears the device's error flags after any failure, and it leaves the device in array-read mode whenever it goes back to idle.

The bus side performs exactly one transfer per request/acknowledge handshake, so device timing belongs to whatever sits on that port.

Top module: `flash_seq`

## Requirements
- R1: After reset the sequencer is idle: `bus_req` and `rsp_valid` are low, and an erase or program request on `cmd_op` sees `cmd_ready` high.
- R2: An erase request (`cmd_op`=0) writes 20h and then D0h, both to the address with its low BLK_W bits cleared. It reads status until bit 7 is 1, then returns `rsp_op`=0 with code 0 on success. The block then reads back as FFh.
- R3: A program request (`cmd_op`=1) writes 40h to the target address and then the data byte to the same address. It polls until status bit 7 is 1 and returns `rsp_op`=1 with code 0 on success.
- R4: A read request (`cmd_op`=2) accepted while idle makes one bus read at the given address, with no command write. It returns `rsp_op`=2, code 0, and the byte on `rsp_rdata`.
- R5: A read request accepted while an erase is being polled writes B0h, then 70h, and polls until bit 7 is 1. If bit 6 is 1, it writes FFh, reads the byte and returns it, then writes D0h and goes on polling the erase. The erase response comes after the read response.
- R6: If bit 6 is 0 after the suspend, the erase response is returned first. FFh is written, the byte is read and returned, and no D0h is written.
- R7: The result code is 1 when status bit 3 is set, whatever the other bits are. Otherwise it is 2 when bits 5 and 4 are both set, 3 when only bit 5 is set, 4 when only bit 4 is set, and 0 when none of them is set. No code above 5 is ever returned.
- R8: After a completion with a nonzero code, the sequencer writes 50h and then FFh before it becomes idle again. After a successful erase or program, it writes only FFh.
- R9: If MAX_POLLS status reads in a row return bit 7 equal to 0, the sequencer returns code 5 on the MAXth such read and then writes 50h and FFh.
- R10: While an erase is outstanding, `cmd_ready` is low for erase and program requests.
- R11: Once `bus_req` is raised, it and the address, direction and write data stay constant until `bus_ack`.
- R12: Every completion is a one-cycle pulse on `rsp_valid`, and two pulses never fall in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 2 | 0 erase, 1 program, 2 read |
| cmd_addr | input | ADDR_W | Byte address of the request |
| cmd_wdata | input | 8 | Byte to program |
| cmd_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Completion strobe |
| rsp_op | output | 2 | Operation that completed |
| rsp_code | output | 3 | Result code (0 ok, 1 range, 2 sequence, 3 erase, 4 write, 5 timeout) |
| rsp_rdata | output | 8 | Byte fetched by a read |
| bus_req | output | 1 | Transfer request to the device |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | 8 | Command or data byte |
| bus_rdata | input | 8 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Transfer complete |

## Verification
Directed runs cover each command flow: programs, erases, reads while idle, and reads during an erase. The bench records every device write in its flash model and compares the command stream with the expected sequence. This separates resume from no-resume and clear-then-restore from restore alone. Injected status flags in every mix check the priority order of the result code. A model that never becomes ready counts the status reads, which exposes an off-by-one in the timeout. Seeded random mixes of programs, erases and reads are then checked against a shadow array, so a wrong address, a missing data write or a wrong block mask shows up as wrong read-back data.

// File: rtl/flash_seq_pkg.sv
// Shared constants for the flash sequencer: request opcodes, result codes,
// device command bytes and status bit positions.
package flash_seq_pkg;
    localparam logic [1:0] OP_ERASE = 2'd0;
    localparam logic [1:0] OP_PROG  = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    localparam logic [2:0] RC_OK      = 3'd0;
    localparam logic [2:0] RC_RANGE   = 3'd1;
    localparam logic [2:0] RC_SEQ     = 3'd2;
    localparam logic [2:0] RC_ERASE   = 3'd3;
    localparam logic [2:0] RC_WRITE   = 3'd4;
    localparam logic [2:0] RC_TIMEOUT = 3'd5;

    localparam logic [7:0] FC_ERASE_SETUP = 8'h20;
    localparam logic [7:0] FC_CONFIRM     = 8'hD0;
    localparam logic [7:0] FC_PROG_SETUP  = 8'h40;
    localparam logic [7:0] FC_SUSPEND     = 8'hB0;
    localparam logic [7:0] FC_STATUS      = 8'h70;
    localparam logic [7:0] FC_CLEAR       = 8'h50;
    localparam logic [7:0] FC_ARRAY       = 8'hFF;

    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;
    localparam int SB_EFAIL = 5;
    localparam int SB_WFAIL = 4;
    localparam int SB_RANGE = 3;

    typedef enum logic [4:0] {
        ST_IDLE, ST_E_SETUP, ST_E_CONF, ST_E_GAP, ST_E_POLL,
        ST_S_SUSP, ST_S_STAT, ST_S_POLL, ST_S_CLR, ST_S_ARRAY,
        ST_S_READ, ST_S_RESUME, ST_P_SETUP, ST_P_DATA, ST_P_POLL,
        ST_R_READ, ST_CLR, ST_RESTORE
    } seq_state_e;
endpackage

// File: rtl/fs_status_check.sv
// Full status check: turns a device status byte into one result code.
// Assumes the byte was read with the ready flag set; range error has priority.
module fs_status_check
    import flash_seq_pkg::*;
(
    input  logic [7:0] status,
    output logic [2:0] code
);
    // Priority decode of the error flags
    always_comb begin
        if (status[SB_RANGE])                          code = RC_RANGE;
        else if (status[SB_EFAIL] && status[SB_WFAIL]) code = RC_SEQ;
        else if (status[SB_EFAIL])                     code = RC_ERASE;
        else if (status[SB_WFAIL])                     code = RC_WRITE;
        else                                           code = RC_OK;
    end
endmodule

// File: rtl/fs_poll_timer.sv
// Counts status reads that found the device busy; flags the last allowed one.
// Assumes miss pulses only while clr is low.
module fs_poll_timer #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    output logic last
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt;

    // Miss counter, cleared outside polling
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (miss)     cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_seq.sv
// Host-side sequencer for a byte-wide command flash. Accepts erase, program
// and read requests, issues command cycles, polls status, runs the full
// status check and the suspend/read/resume flow. One bus transfer per
// req/ack handshake; bus_rdata is valid in the ack cycle.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_W     = 16,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              cmd_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic [2:0]        rsp_code,
    output logic [7:0]        rsp_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << BLK_W;

    seq_state_e        state;
    logic [ADDR_W-1:0] blk_q, addr_q, raddr_q;
    logic [7:0]        data_q;
    logic              resume_q;
    logic [2:0]        chk_code;
    logic              poll_st, poll_last, accept, ready_bit;

    fs_status_check u_check (.status(bus_rdata), .code(chk_code));

    assign poll_st   = (state == ST_E_POLL) || (state == ST_S_POLL) || (state == ST_P_POLL);
    assign ready_bit = bus_rdata[SB_READY];

    fs_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!poll_st && state != ST_E_GAP),
        .miss (poll_st && bus_ack && !ready_bit),
        .last (poll_last)
    );

    // Request acceptance: new work when idle, reads only between erase polls
    always_comb begin
        cmd_ready = ((state == ST_IDLE) && (cmd_op != 2'd3)) ||
                    ((state == ST_E_GAP) && (cmd_op == OP_READ));
    end
    assign accept = cmd_valid && cmd_ready;

    // Bus transfer selected by the current step
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = blk_q;
        bus_wdata = 8'h00;
        unique case (state)
            ST_IDLE, ST_E_GAP: bus_req = 1'b0;
            ST_E_SETUP:  bus_wdata = FC_ERASE_SETUP;
            ST_E_CONF:   bus_wdata = FC_CONFIRM;
            ST_E_POLL:   bus_we = 1'b0;
            ST_S_SUSP:   bus_wdata = FC_SUSPEND;
            ST_S_STAT:   bus_wdata = FC_STATUS;
            ST_S_POLL:   bus_we = 1'b0;
            ST_S_CLR:    bus_wdata = FC_CLEAR;
            ST_S_ARRAY:  bus_wdata = FC_ARRAY;
            ST_S_READ:   begin bus_we = 1'b0; bus_addr = raddr_q; end
            ST_S_RESUME: bus_wdata = FC_CONFIRM;
            ST_P_SETUP:  begin bus_addr = addr_q; bus_wdata = FC_PROG_SETUP; end
            ST_P_DATA:   begin bus_addr = addr_q; bus_wdata = data_q; end
            ST_P_POLL:   begin bus_we = 1'b0; bus_addr = addr_q; end
            ST_R_READ:   begin bus_we = 1'b0; bus_addr = raddr_q; end
            ST_CLR:      bus_wdata = FC_CLEAR;
            ST_RESTORE:  bus_wdata = FC_ARRAY;
            default:     bus_req = 1'b0;
        endcase
    end

    // Step sequencing and response generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            blk_q     <= '0;
            addr_q    <= '0;
            raddr_q   <= '0;
            data_q    <= '0;
            resume_q  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_op    <= OP_ERASE;
            rsp_code  <= RC_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (cmd_op == OP_ERASE) begin
                        blk_q <= cmd_addr & BLK_MASK;
                        state <= ST_E_SETUP;
                    end else if (cmd_op == OP_PROG) begin
                        addr_q <= cmd_addr;
                        data_q <= cmd_wdata;
                        state  <= ST_P_SETUP;
                    end else begin
                        raddr_q <= cmd_addr;
                        state   <= ST_R_READ;
                    end
                end
                ST_E_SETUP: if (bus_ack) state <= ST_E_CONF;
                ST_E_CONF:  if (bus_ack) state <= ST_E_GAP;
                ST_E_GAP: begin
                    if (accept) begin
                        raddr_q <= cmd_addr;
                        state   <= ST_S_SUSP;
                    end else begin
                        state <= ST_E_POLL;
                    end
                end
                ST_E_POLL, ST_P_POLL: if (bus_ack) begin
                    if (ready_bit || poll_last) begin
                        rsp_valid <= 1'b1;
                        rsp_op    <= (state == ST_E_POLL) ? OP_ERASE : OP_PROG;
                        rsp_code  <= ready_bit ? chk_code : RC_TIMEOUT;
                        state     <= (ready_bit && chk_code == RC_OK) ? ST_RESTORE : ST_CLR;
                    end else if (state == ST_E_POLL) begin
                        state <= ST_E_GAP;
                    end
                end
                ST_S_SUSP: if (bus_ack) state <= ST_S_STAT;
                ST_S_STAT: if (bus_ack) state <= ST_S_POLL;
                ST_S_POLL: if (bus_ack) begin
                    if (ready_bit && bus_rdata[SB_SUSP]) begin
                        resume_q <= 1'b1;
                        state    <= ST_S_ARRAY;
                    end else if (ready_bit) begin
                        resume_q  <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_op    <= OP_ERASE;
                        rsp_code  <= chk_code;
                        state     <= (chk_code == RC_OK) ? ST_S_ARRAY : ST_S_CLR;
                    end else if (poll_last) begin
                        rsp_valid <= 1'b1;
                        rsp_op    <= OP_READ;
                        rsp_code  <= RC_TIMEOUT;
                        state     <= ST_CLR;
                    end
                end
                ST_S_CLR:   if (bus_ack) state <= ST_S_ARRAY;
                ST_S_ARRAY: if (bus_ack) state <= ST_S_READ;
                ST_S_READ, ST_R_READ: if (bus_ack) begin
                    rsp_valid <= 1'b1;
                    rsp_op    <= OP_READ;
                    rsp_code  <= RC_OK;
                    rsp_rdata <= bus_rdata;
                    state     <= (state == ST_S_READ && resume_q) ? ST_S_RESUME : ST_IDLE;
                end
                ST_S_RESUME: if (bus_ack) state <= ST_E_GAP;
                ST_P_SETUP:  if (bus_ack) state <= ST_P_DATA;
                ST_P_DATA:   if (bus_ack) state <= ST_P_POLL;
                ST_CLR:      if (bus_ack) state <= ST_RESTORE;
                ST_RESTORE:  if (bus_ack) state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_chk.sv
// Protocol checker for flash_seq, attached by bind. Tracks whether an erase
// is outstanding from the request/response ports only.
module flash_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_op,
    input logic [2:0]        rsp_code,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack
);
    logic erase_open;
    logic rst_q;

    // Erase outstanding between its acceptance and its response or a timeout
    always_ff @(posedge clk) begin
        if (!rst_n) erase_open <= 1'b0;
        else if (cmd_valid && cmd_ready && cmd_op == 2'd0) erase_open <= 1'b1;
        else if (rsp_valid && (rsp_op == 2'd0 || rsp_code == 3'd5)) erase_open <= 1'b0;
    end

    // Previous reset level, to check the first cycle after release
    always_ff @(posedge clk) rst_q <= rst_n;

    // First cycle out of reset is quiet
    always_ff @(posedge clk) begin
        if (rst_n && !rst_q) begin
            assert_reset_quiet_R1: assert (!bus_req && !rsp_valid)
                else $error("bus or response active right after reset");
        end
    end

    assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_code <= 3'd5);

    assert_erase_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_open && cmd_op != 2'd2) |-> !cmd_ready);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_op(rsp_op),
    .rsp_code(rsp_code), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/flash_seq_bench.sv
// Bench for flash_seq: behavioural flash model, directed flows and a seeded
// random mix, checked against a shadow array and a command-write log.
module flash_seq_bench;
    localparam int AW = 8;
    localparam int BW = 4;
    localparam int MP = 20;
    localparam int ERASE_LAT = 30;
    localparam int PROG_LAT  = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_wdata;
    logic          cmd_ready, rsp_valid;
    logic [1:0]    rsp_op;
    logic [2:0]    rsp_code;
    logic [7:0]    rsp_rdata;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .BLK_W(BW), .MAX_POLLS(MP)) u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_code(rsp_code),
        .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    // ---------------- flash model ----------------
    logic [7:0] mem [0:255];
    logic [7:0] sr;
    logic [7:0] inj = 8'h00;
    bit         stall = 1'b0;
    bit         fin_on_susp = 1'b0;
    int         mode_st, pend, busy_kind, busy_cnt, susp_cnt, rd_cnt, wl;
    bit         suspended;
    logic [7:0] ers_blk;
    logic [7:0] log_d [0:1023];
    logic [7:0] log_a [0:1023];

    task automatic fill_block(input logic [7:0] b);
        for (int i = 0; i < 16; i++) mem[{b[7:4], 4'(i)}] = 8'hFF;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
            sr = 8'h80; mode_st = 0; pend = 0; busy_kind = 0; busy_cnt = 0;
            susp_cnt = 0; suspended = 0; rd_cnt = 0; wl = 0; ers_blk = 0;
            bus_ack <= 1'b0; bus_rdata <= 8'h00;
        end else begin
            bus_ack <= 1'b0;
            if (suspended && susp_cnt > 0) begin
                susp_cnt = susp_cnt - 1;
                if (susp_cnt == 0) begin sr[7] = 1'b1; sr[6] = 1'b1; end
            end else if (busy_kind != 0 && !suspended && !stall) begin
                if (busy_cnt == 0) begin
                    if (busy_kind == 1) fill_block(ers_blk);
                    busy_kind = 0; sr[7] = 1'b1; sr = sr | inj;
                end else busy_cnt = busy_cnt - 1;
            end
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (bus_we) begin
                    log_d[wl] = bus_wdata; log_a[wl] = bus_addr; wl = wl + 1;
                    if (pend == 1) begin
                        pend = 0;
                        if (bus_wdata == 8'hD0) begin
                            ers_blk = bus_addr; busy_kind = 1; busy_cnt = ERASE_LAT;
                            sr[7] = 1'b0; mode_st = 1;
                        end
                    end else if (pend == 2) begin
                        pend = 0; mem[bus_addr] = mem[bus_addr] & bus_wdata;
                        busy_kind = 2; busy_cnt = PROG_LAT; sr[7] = 1'b0; mode_st = 1;
                    end else begin
                        case (bus_wdata)
                            8'h20: pend = 1;
                            8'h40: pend = 2;
                            8'h70: mode_st = 1;
                            8'h50: sr[5:3] = 3'b000;
                            8'hFF: mode_st = 0;
                            8'hB0: begin
                                mode_st = 1;
                                if (busy_kind == 1 && !suspended) begin
                                    if (fin_on_susp) begin
                                        fill_block(ers_blk); busy_kind = 0;
                                        sr[7] = 1'b1; sr[6] = 1'b0;
                                    end else begin
                                        suspended = 1; susp_cnt = 3; sr[7] = 1'b0;
                                    end
                                end
                            end
                            8'hD0: if (suspended) begin
                                suspended = 0; sr[6] = 1'b0; sr[7] = 1'b0; mode_st = 1;
                            end
                            default: ;
                        endcase
                    end
                end else begin
                    rd_cnt = rd_cnt + 1;
                    bus_rdata <= (mode_st == 1) ? sr : mem[bus_addr];
                end
            end
        end
    end

    // ---------------- response capture ----------------
    logic [1:0] rq_op   [0:1023];
    logic [2:0] rq_code [0:1023];
    logic [7:0] rq_data [0:1023];
    int rn = 0, rr = 0;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            rq_op[rn] = rsp_op; rq_code[rn] = rsp_code; rq_data[rn] = rsp_rdata; rn = rn + 1;
        end
    end

    // ---------------- checking helpers ----------------
    int errs = 0, checks = 0;
    logic [7:0] exp_mem [0:255];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input logic [7:0] f);
        if (f[3]) return 1;
        if (f[5] && f[4]) return 2;
        if (f[5]) return 3;
        if (f[4]) return 4;
        return 0;
    endfunction

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
        int n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        #1;
        while (!cmd_ready && n < 5000) begin @(negedge clk); #1; n++; end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic get_rsp(output logic [1:0] op, output logic [2:0] code, output logic [7:0] d);
        int n = 0;
        while (rr == rn && n < 3000) begin @(negedge clk); n++; end
        if (rr == rn) begin
            chk(1'b0, "response missing", 0, 1);
            op = 2'd3; code = 3'd7; d = 8'h00;
        end else begin
            op = rq_op[rr]; code = rq_code[rr]; d = rq_data[rr]; rr++;
        end
    endtask

    task automatic run_prog(input logic [7:0] a, input logic [7:0] d, input int ecode);
        logic [1:0] op; logic [2:0] c; logic [7:0] r; int s;
        s = wl;
        do_cmd(2'd1, a, d);
        exp_mem[a] = exp_mem[a] & d;
        get_rsp(op, c, r);
        chk(op == 2'd1, "R3 program rsp_op", op, 1);
        chk(c == 3'(ecode), "R7 program code", c, ecode);
        repeat (8) @(negedge clk);
        chk(log_d[s] == 8'h40 && log_a[s] == a, "R3 setup write", log_d[s], 8'h40);
        chk(log_d[s+1] == d && log_a[s+1] == a, "R3 data write", log_d[s+1], d);
        if (ecode == 0) begin
            chk(log_d[s+2] == 8'hFF && wl == s + 3, "R8 restore only", wl - s, 3);
        end else begin
            chk(log_d[s+2] == 8'h50 && log_d[s+3] == 8'hFF && wl == s + 4,
                "R8 clear then restore", log_d[s+2], 8'h50);
        end
    endtask

    task automatic run_read(input logic [7:0] a);
        logic [1:0] op; logic [2:0] c; logic [7:0] r; int s;
        s = wl;
        do_cmd(2'd2, a, 8'h00);
        get_rsp(op, c, r);
        chk(op == 2'd2 && c == 3'd0, "R4 read rsp", {op, c}, 8'h10);
        chk(r == exp_mem[a], "R4 read data", r, exp_mem[a]);
        chk(wl == s, "R4 no command write", wl - s, 0);
    endtask

    task automatic run_erase(input logic [7:0] a, input int ecode);
        logic [1:0] op; logic [2:0] c; logic [7:0] r; int s;
        logic [7:0] b;
        s = wl; b = {a[7:4], 4'h0};
        do_cmd(2'd0, a, 8'h00);
        get_rsp(op, c, r);
        chk(op == 2'd0, "R2 erase rsp_op", op, 0);
        chk(c == 3'(ecode), "R7 erase code", c, ecode);
        repeat (8) @(negedge clk);
        chk(log_d[s] == 8'h20 && log_a[s] == b, "R2 erase setup", log_a[s], b);
        chk(log_d[s+1] == 8'hD0 && log_a[s+1] == b, "R2 erase confirm", log_d[s+1], 8'hD0);
        if (ecode == 0) chk(log_d[s+2] == 8'hFF && wl == s + 3, "R8 erase restore", wl - s, 3);
        else chk(log_d[s+2] == 8'h50 && log_d[s+3] == 8'hFF, "R8 erase clear", log_d[s+2], 8'h50);
        for (int i = 0; i < 16; i++) exp_mem[{b[7:4], 4'(i)}] = 8'hFF;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [1:0] op; logic [2:0] c; logic [7:0] r; int s, s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cmd_ready && !bus_req && !rsp_valid, "R1 reset state",
            {cmd_ready, bus_req, rsp_valid}, 3'b100);

        run_read(8'h10);
        run_read(8'hA7);
        run_prog(8'h25, 8'h5A, 0);
        run_read(8'h25);

        // erase with blocked requests during it
        s = wl;
        do_cmd(2'd0, 8'h3A, 8'h00);
        @(negedge clk);
        cmd_op = 2'd1; #1; chk(!cmd_ready, "R10 program blocked", cmd_ready, 0);
        cmd_op = 2'd0; #1; chk(!cmd_ready, "R10 erase blocked", cmd_ready, 0);
        get_rsp(op, c, r);
        chk(op == 2'd0 && c == 3'd0, "R2 erase done", {op, c}, 0);
        repeat (8) @(negedge clk);
        chk(log_d[s] == 8'h20 && log_a[s] == 8'h30 && log_d[s+1] == 8'hD0 && log_a[s+1] == 8'h30,
            "R2 block-aligned commands", log_a[s], 8'h30);
        chk(log_d[s+2] == 8'hFF && wl == s + 3, "R8 erase restore", wl - s, 3);
        for (int i = 0; i < 16; i++) exp_mem[8'h30 + i] = 8'hFF;
        run_read(8'h30);
        run_read(8'h3F);

        // read during erase, erase still running at suspend (R5)
        s = wl;
        do_cmd(2'd0, 8'h55, 8'h00);
        do_cmd(2'd2, 8'h72, 8'h00);
        get_rsp(op, c, r);
        chk(op == 2'd2 && r == exp_mem[8'h72], "R5 suspended read", r, exp_mem[8'h72]);
        get_rsp(op, c, r);
        chk(op == 2'd0 && c == 3'd0, "R5 erase after resume", {op, c}, 0);
        repeat (8) @(negedge clk);
        chk(log_d[s+2] == 8'hB0 && log_d[s+3] == 8'h70 && log_d[s+4] == 8'hFF,
            "R5 suspend commands", log_d[s+2], 8'hB0);
        chk(log_d[s+5] == 8'hD0 && log_d[s+6] == 8'hFF && wl == s + 7, "R5 resume", log_d[s+5], 8'hD0);
        for (int i = 0; i < 16; i++) exp_mem[8'h50 + i] = 8'hFF;
        run_read(8'h5C);

        // read during erase, erase already over at suspend (R6)
        fin_on_susp = 1'b1;
        s = wl;
        do_cmd(2'd0, 8'h61, 8'h00);
        do_cmd(2'd2, 8'h81, 8'h00);
        get_rsp(op, c, r);
        chk(op == 2'd0 && c == 3'd0, "R6 erase reported first", {op, c}, 0);
        get_rsp(op, c, r);
        chk(op == 2'd2 && r == exp_mem[8'h81], "R6 read data", r, exp_mem[8'h81]);
        repeat (8) @(negedge clk);
        chk(log_d[s+2] == 8'hB0 && log_d[s+3] == 8'h70 && log_d[s+4] == 8'hFF && wl == s + 5,
            "R6 no resume", wl - s, 5);
        fin_on_susp = 1'b0;
        for (int i = 0; i < 16; i++) exp_mem[8'h60 + i] = 8'hFF;
        run_read(8'h6E);

        // error flag decoding (R7, R8)
        inj = 8'h08; run_prog(8'h90, 8'hF0, exp_code(8'h08)); inj = 8'h00;
        inj = 8'h30; run_prog(8'h91, 8'h0F, exp_code(8'h30)); inj = 8'h00;
        inj = 8'h10; run_prog(8'h92, 8'h33, exp_code(8'h10)); inj = 8'h00;
        inj = 8'h38; run_prog(8'h93, 8'hCC, exp_code(8'h38)); inj = 8'h00;
        inj = 8'h20; run_erase(8'hC4, exp_code(8'h20)); inj = 8'h00;
        run_prog(8'h94, 8'h77, 0);

        // polling timeout (R9)
        stall = 1'b1;
        s0 = rd_cnt;
        s = wl;
        do_cmd(2'd1, 8'hF3, 8'h0F);
        exp_mem[8'hF3] = exp_mem[8'hF3] & 8'h0F;
        get_rsp(op, c, r);
        chk(op == 2'd1 && c == 3'd5, "R9 timeout code", c, 5);
        chk(rd_cnt - s0 == MP, "R9 poll count", rd_cnt - s0, MP);
        repeat (8) @(negedge clk);
        chk(log_d[s+2] == 8'h50 && log_d[s+3] == 8'hFF, "R9 clear and restore", log_d[s+2], 8'h50);
        stall = 1'b0;
        repeat (20) @(negedge clk);

        // seeded random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, d;
            int sel;
            a = 8'($urandom); d = 8'($urandom); sel = int'($urandom % 5);
            if (sel < 2) run_prog(a, d, 0);
            else if (sel < 4) run_read(a);
            else run_erase(a, 0);
        end
        for (int k = 0; k < 12; k++) run_read(8'($urandom));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule